// File: doc/BRIEF.md
# Two-Channel Time Interval Averager

This block times the gap between an edge on a start channel and a later edge on a stop channel. It does this by counting cycles of its reference clock. Each channel has its own edge polarity select, so one block can time the delay between two separate signals. It can also time the high or low width of a single signal wired to both channels.

Completed intervals are summed over a programmable gate window. At the end of each window the block publishes the tick sum and the interval count together, so that downstream logic can form the mean interval.

If a window closes with no completed interval, the block keeps the window open for a bounded tail. During the tail, the first interval that completes is published at once. If none completes, a zero result is published with a flag. Both channel inputs arrive already synchronised to the clock. A selectable debounce filter sits in front of the edge detectors.

Top module: `interval_averager`

## Requirements
- R1: Timing starts on the selected edge of `chan_a` and stops on the selected edge of `chan_b`. A polarity select of 0 picks the rising edge and 1 picks the falling edge; each channel has its own select.
- R2: With one signal wired to both channels and opposite polarities selected, the measured interval is the width of the high pulse (start rising, stop falling) or of the low pulse (start falling, stop rising).
- R3: An interval's value is the number of reference clock cycles between the start edge and the stop edge. Both channels see the same filter delay, so the value equals the spacing of the two raw edges in cycles.
- R4: A window lasts `gate_len` cycles, counted from the end of reset or from the previous publication. If at least one interval completed in it, the block publishes the tick sum and the interval count (count nonzero, zero flag low) in the cycle the window ends.
- R5: `db_sel` picks the debounce hold: 0 means none, 1 means the short hold, and 2 or 3 mean the long hold. A level that lasts fewer cycles than the hold produces no edge.
- R6: A stop edge that arrives while no measurement is running is ignored. A start edge that arrives while a measurement is running neither restarts it nor changes its result.
- R7: An interval still running when a window ends is counted whole in the window in which it completes, and never partially in the earlier one.
- R8: If a window ends with no completed interval, it is extended by a tail of TAIL cycles (nominally 30 ms of ticks). The first interval completing in the tail is published at once. Otherwise, sum 0 and count 0 are published with the zero flag high exactly TAIL cycles after the gate ends.
- R9: The tick sum and the interval count saturate at their maximum values. Any saturation in a window, including of a single interval's tick count, sets the overflow output for that window's result. The flag clears for the following window.
- R10: `valid_o` is high for exactly one cycle per result. `sum_o`, `count_o`, `zero_o` and `ovf_o` hold their values until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference tick clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_a | input | 1 | Start channel, synchronised |
| chan_b | input | 1 | Stop channel, synchronised |
| a_fall | input | 1 | Start polarity: 0 rising, 1 falling |
| b_fall | input | 1 | Stop polarity: 0 rising, 1 falling |
| db_sel | input | 2 | Debounce hold: 0 none, 1 short, 2/3 long |
| gate_len | input | GATE_W | Window length in cycles |
| sum_o | output | ACC_W | Sum of interval ticks in the last window |
| count_o | output | CNT_W | Intervals completed in the last window |
| valid_o | output | 1 | One-cycle result strobe |
| zero_o | output | 1 | Result is a timeout zero |
| ovf_o | output | 1 | Saturation occurred in the last window |

## Verification
The main function is driven four ways, each separating a different fault:
- Separate start and stop channels with several interval lengths in one window show that durations add up correctly and the count is right.
- A single wired signal under both polarity pairings shows whether the two channels honour their own polarity.
- Stray stop pulses, repeated start pulses and short glitches are placed ahead of real intervals; they show whether the arming logic and each debounce hold reject what they must.
- Intervals placed across a window boundary, inside the timeout tail, or absent altogether, with exact strobe cycles checked, tell carry-over, tail completion and the zero report apart. Long and very many intervals push both accumulators into saturation.

// File: rtl/tia_pkg.sv
package tia_pkg;
  typedef enum logic [1:0] {
    DB_OFF   = 2'b00,
    DB_SHORT = 2'b01,
    DB_LONG  = 2'b10,
    DB_LONG2 = 2'b11
  } db_mode_t;

  typedef enum logic {
    WIN_OPEN   = 1'b0,
    WIN_EXTEND = 1'b1
  } win_state_t;
endpackage

// File: rtl/tia_edge_filter.sv
module tia_edge_filter #(
  parameter int LIM_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             raw,
  input  logic             fall_sel,
  input  logic [LIM_W-1:0] lim,
  output logic             edge_o
);
  logic             filt;
  logic             filt_q;
  logic [LIM_W-1:0] dcnt;
  logic             reach;

  // level must differ from the filtered value for lim consecutive samples
  assign reach = ({1'b0, dcnt} + (LIM_W+1)'(1)) >= {1'b0, lim};

  always_ff @(posedge clk) begin
    if (rst) begin
      filt   <= 1'b0;
      filt_q <= 1'b0;
      dcnt   <= '0;
    end else begin
      filt_q <= filt;
      if (raw == filt) begin
        dcnt <= '0;
      end else if (reach) begin
        filt <= raw;
        dcnt <= '0;
      end else begin
        dcnt <= dcnt + LIM_W'(1);
      end
    end
  end

  assign edge_o = fall_sel ? (filt_q & ~filt) : (filt & ~filt_q);
endmodule

// File: rtl/tia_interval_timer.sv
module tia_interval_timer #(
  parameter int DUR_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_ev,
  input  logic             stop_ev,
  output logic             busy_o,
  output logic             done_o,
  output logic [DUR_W-1:0] dur_o,
  output logic             sat_o
);
  localparam logic [DUR_W-1:0] DUR_MAX = '1;

  logic [DUR_W-1:0] ticks;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
      ticks  <= '0;
      dur_o  <= '0;
      sat_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!busy_o) begin
        // stop while idle is dropped
        if (start_ev) begin
          busy_o <= 1'b1;
          ticks  <= '0;
        end
      end else if (stop_ev) begin
        busy_o <= 1'b0;
        done_o <= 1'b1;
        dur_o  <= (ticks == DUR_MAX) ? DUR_MAX : ticks + DUR_W'(1);
        sat_o  <= (ticks == DUR_MAX);
      end else if (ticks != DUR_MAX) begin
        // start while running is dropped
        ticks <= ticks + DUR_W'(1);
      end
    end
  end
endmodule

// File: rtl/tia_window_accum.sv
module tia_window_accum
  import tia_pkg::*;
#(
  parameter int ACC_W  = 48,
  parameter int CNT_W  = 24,
  parameter int DUR_W  = 32,
  parameter int GATE_W = 32,
  parameter int TAIL   = 165000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [GATE_W-1:0] gate_len,
  input  logic              done,
  input  logic [DUR_W-1:0]  dur,
  input  logic              dur_sat,
  output logic [ACC_W-1:0]  sum_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              valid_o,
  output logic              zero_o,
  output logic              ovf_o
);
  localparam int TW = $clog2(TAIL + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  win_state_t        state;
  logic [GATE_W-1:0] gcnt;
  logic [TW-1:0]     tcnt;
  logic [ACC_W-1:0]  acc;
  logic [CNT_W-1:0]  cnt;
  logic              ovf;

  logic [ACC_W:0]    addend;
  logic [ACC_W:0]    acc_ext;
  logic [ACC_W-1:0]  acc_n;
  logic [CNT_W-1:0]  cnt_n;
  logic              cnt_sat;
  logic              ovf_n;
  logic              gexp;
  logic              tail_end;

  always_comb begin
    addend  = done ? {{(ACC_W+1-DUR_W){1'b0}}, dur} : '0;
    acc_ext = {1'b0, acc} + addend;
    acc_n   = acc_ext[ACC_W] ? '1 : acc_ext[ACC_W-1:0];
    cnt_sat = done && (cnt == CNT_MAX);
    if (!done)        cnt_n = cnt;
    else if (cnt_sat) cnt_n = CNT_MAX;
    else              cnt_n = cnt + CNT_W'(1);
    ovf_n    = ovf | acc_ext[ACC_W] | cnt_sat | (done & dur_sat);
    gexp     = ({1'b0, gcnt} + (GATE_W+1)'(1)) >= {1'b0, gate_len};
    tail_end = (tcnt == TW'(TAIL - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= WIN_OPEN;
      gcnt    <= '0;
      tcnt    <= '0;
      acc     <= '0;
      cnt     <= '0;
      ovf     <= 1'b0;
      sum_o   <= '0;
      count_o <= '0;
      valid_o <= 1'b0;
      zero_o  <= 1'b0;
      ovf_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      acc     <= acc_n;
      cnt     <= cnt_n;
      ovf     <= ovf_n;
      case (state)
        WIN_OPEN: begin
          if (gexp) begin
            gcnt <= '0;
            if (cnt_n != '0) begin
              sum_o   <= acc_n;
              count_o <= cnt_n;
              zero_o  <= 1'b0;
              ovf_o   <= ovf_n;
              valid_o <= 1'b1;
              acc     <= '0;
              cnt     <= '0;
              ovf     <= 1'b0;
            end else begin
              state <= WIN_EXTEND;
              tcnt  <= '0;
            end
          end else begin
            gcnt <= gcnt + GATE_W'(1);
          end
        end
        WIN_EXTEND: begin
          if (done) begin
            sum_o   <= acc_n;
            count_o <= cnt_n;
            zero_o  <= 1'b0;
            ovf_o   <= ovf_n;
            valid_o <= 1'b1;
            acc     <= '0;
            cnt     <= '0;
            ovf     <= 1'b0;
            state   <= WIN_OPEN;
          end else if (tail_end) begin
            sum_o   <= '0;
            count_o <= '0;
            zero_o  <= 1'b1;
            ovf_o   <= ovf_n;
            valid_o <= 1'b1;
            ovf     <= 1'b0;
            state   <= WIN_OPEN;
          end else begin
            tcnt <= tcnt + TW'(1);
          end
        end
        default: state <= WIN_OPEN;
      endcase
    end
  end
endmodule

// File: rtl/interval_averager.sv
module interval_averager
  import tia_pkg::*;
#(
  parameter int TICK_HZ     = 5500000,
  parameter int DB_SHORT_MS = 3,
  parameter int DB_LONG_MS  = 50,
  parameter int TAIL_MS     = 30,
  parameter int ACC_W       = 48,
  parameter int CNT_W       = 24,
  parameter int DUR_W       = 32,
  parameter int GATE_W      = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chan_a,
  input  logic              chan_b,
  input  logic              a_fall,
  input  logic              b_fall,
  input  logic [1:0]        db_sel,
  input  logic [GATE_W-1:0] gate_len,
  output logic [ACC_W-1:0]  sum_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              valid_o,
  output logic              zero_o,
  output logic              ovf_o
);
  localparam int TPM       = TICK_HZ / 1000;
  localparam int DB_S_RAW  = TPM * DB_SHORT_MS;
  localparam int DB_L_RAW  = TPM * DB_LONG_MS;
  localparam int TAIL_RAW  = TPM * TAIL_MS;
  localparam int DB_S_CYC  = (DB_S_RAW < 1) ? 1 : DB_S_RAW;
  localparam int DB_L_CYC  = (DB_L_RAW < 1) ? 1 : DB_L_RAW;
  localparam int TAIL_CYC  = (TAIL_RAW < 1) ? 1 : TAIL_RAW;
  localparam int LIM_W     = $clog2(DB_L_CYC + 1);

  logic [LIM_W-1:0] lim;
  logic [1:0]       raw_v;
  logic [1:0]       fall_v;
  logic [1:0]       edge_v;
  logic             tmr_busy;
  logic             tmr_done;
  logic [DUR_W-1:0] tmr_dur;
  logic             tmr_sat;

  always_comb begin
    case (db_mode_t'(db_sel))
      DB_OFF:   lim = LIM_W'(1);
      DB_SHORT: lim = LIM_W'(DB_S_CYC);
      default:  lim = LIM_W'(DB_L_CYC);
    endcase
  end

  assign raw_v  = {chan_b, chan_a};
  assign fall_v = {b_fall, a_fall};

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    tia_edge_filter #(.LIM_W(LIM_W)) u_filt (
      .clk      (clk),
      .rst      (rst),
      .raw      (raw_v[ch]),
      .fall_sel (fall_v[ch]),
      .lim      (lim),
      .edge_o   (edge_v[ch])
    );
  end

  tia_interval_timer #(.DUR_W(DUR_W)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .start_ev (edge_v[0]),
    .stop_ev  (edge_v[1]),
    .busy_o   (tmr_busy),
    .done_o   (tmr_done),
    .dur_o    (tmr_dur),
    .sat_o    (tmr_sat)
  );

  tia_window_accum #(
    .ACC_W  (ACC_W),
    .CNT_W  (CNT_W),
    .DUR_W  (DUR_W),
    .GATE_W (GATE_W),
    .TAIL   (TAIL_CYC)
  ) u_win (
    .clk      (clk),
    .rst      (rst),
    .gate_len (gate_len),
    .done     (tmr_done),
    .dur      (tmr_dur),
    .dur_sat  (tmr_sat),
    .sum_o    (sum_o),
    .count_o  (count_o),
    .valid_o  (valid_o),
    .zero_o   (zero_o),
    .ovf_o    (ovf_o)
  );
endmodule

// File: rtl/tia_chk.sv
module tia_chk #(
  parameter int ACC_W = 48,
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             valid_o,
  input logic             zero_o,
  input logic [ACC_W-1:0] sum_o,
  input logic [CNT_W-1:0] count_o,
  input logic             done,
  input logic             busy
);
  // R10
  strobe_width_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> ($stable(sum_o) && $stable(count_o) && $stable(zero_o)));

  // R8
  zero_result_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_o && zero_o) |-> (sum_o == '0 && count_o == '0));

  // R4
  nonzero_count_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !zero_o) |-> (count_o != '0));

  // R6
  armed_stop_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(busy) && !busy));
endmodule

bind interval_averager tia_chk #(.ACC_W(ACC_W), .CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .valid_o (valid_o),
  .zero_o  (zero_o),
  .sum_o   (sum_o),
  .count_o (count_o),
  .done    (tmr_done),
  .busy    (tmr_busy)
);

// File: tb/sim_interval_averager.sv
module sim_interval_averager;
  localparam int ACC_W  = 8;
  localparam int CNT_W  = 3;
  localparam int DUR_W  = 8;
  localparam int GATE_W = 16;
  localparam int TAIL   = 30;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              chan_a = 1'b0;
  logic              chan_b = 1'b0;
  logic              a_fall = 1'b0;
  logic              b_fall = 1'b0;
  logic [1:0]        db_sel = 2'd0;
  logic [GATE_W-1:0] gate_len = 16'd100;
  logic [ACC_W-1:0]  sum_o;
  logic [CNT_W-1:0]  count_o;
  logic              valid_o;
  logic              zero_o;
  logic              ovf_o;

  interval_averager #(
    .TICK_HZ(1000), .DB_SHORT_MS(3), .DB_LONG_MS(50), .TAIL_MS(TAIL),
    .ACC_W(ACC_W), .CNT_W(CNT_W), .DUR_W(DUR_W), .GATE_W(GATE_W)
  ) u0 (
    .clk(clk), .rst(rst), .chan_a(chan_a), .chan_b(chan_b),
    .a_fall(a_fall), .b_fall(b_fall), .db_sel(db_sel), .gate_len(gate_len),
    .sum_o(sum_o), .count_o(count_o), .valid_o(valid_o),
    .zero_o(zero_o), .ovf_o(ovf_o)
  );

  always #4 clk = ~clk;

  typedef struct {
    int    sum;
    int    cnt;
    bit    zero;
    bit    ovf;
    int    cyc;
    string tag;
  } exp_t;

  exp_t q[$];
  int   vectors = 0;
  int   errors  = 0;
  int   cyc     = 0;
  bit   prev_valid = 1'b0;
  bit   done_flag  = 1'b0;

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expv);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  // monitor: pops expected results as strobes appear
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_valid && valid_o)
        check(1'b0, "R10", "strobe longer than one cycle", 1, 0);
      if (valid_o) begin
        if (q.size() == 0) begin
          check(1'b0, "R4", "unexpected result strobe", int'(sum_o), -1);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(int'(sum_o) == e.sum, e.tag, "sum", int'(sum_o), e.sum);
          check(int'(count_o) == e.cnt, e.tag, "count", int'(count_o), e.cnt);
          check(zero_o == e.zero, e.tag, "zero flag", int'(zero_o), int'(e.zero));
          check(ovf_o == e.ovf, e.tag, "overflow flag", int'(ovf_o), int'(e.ovf));
          if (e.cyc != 0)
            check(cyc == e.cyc, e.tag, "strobe cycle", cyc, e.cyc);
        end
      end
    end
    prev_valid = valid_o;
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "WATCHDOG", "run did not finish", 0, 1);
    summary();
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input int s, input int c, input bit z, input bit o,
                      input int cy, input string tag);
    exp_t e;
    e.sum = s; e.cnt = c; e.zero = z; e.ovf = o; e.cyc = cy; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic do_reset(input bit af, input bit bf, input logic [1:0] db,
                          input int g);
    @(negedge clk);
    rst = 1'b1; chan_a = 1'b0; chan_b = 1'b0;
    a_fall = af; b_fall = bf; db_sel = db; gate_len = GATE_W'(g);
    tick(3);
    rst = 1'b0;
  endtask

  task automatic drain(input string tag);
    int w = 0;
    while (q.size() > 0 && w < 3000) begin
      tick(1);
      w++;
    end
    if (q.size() > 0) begin
      check(1'b0, tag, "missing result strobe", 0, q.size());
      q.delete();
    end
    tick(2);
  endtask

  task automatic wait_cyc(input int c);
    while (cyc < c) tick(1);
  endtask

  // start on chan_a rise, stop on chan_b rise d cycles later
  task automatic interval(input int d, input int hold);
    chan_a = 1'b1;
    tick(d);
    chan_b = 1'b1;
    tick(hold);
    chan_a = 1'b0; chan_b = 1'b0;
    tick(hold);
  endtask

  task automatic both(input logic v);
    chan_a = v; chan_b = v;
  endtask

  initial begin
    // reset state
    do_reset(1'b0, 1'b0, 2'd0, 200);
    tick(1);
    check(sum_o == '0, "R10", "reset sum", int'(sum_o), 0);
    check(count_o == '0, "R10", "reset count", int'(count_o), 0);
    check(valid_o == 1'b0, "R10", "reset strobe", int'(valid_o), 0);
    check(zero_o == 1'b0 && ovf_o == 1'b0, "R9", "reset flags",
          int'({zero_o, ovf_o}), 0);

    // R1 R3 R4: three separate intervals summed in one window
    push(22, 3, 1'b0, 1'b0, 200, "R1/R3/R4");
    tick(4);
    interval(5, 3); interval(7, 3); interval(10, 3);
    drain("R4");

    // R2: tied signal, high width
    do_reset(1'b0, 1'b1, 2'd0, 100);
    push(15, 2, 1'b0, 1'b0, 100, "R2 high width");
    tick(4);
    both(1'b1); tick(6); both(1'b0); tick(5);
    both(1'b1); tick(9); both(1'b0); tick(5);
    drain("R2");

    // R2: tied signal, low width
    do_reset(1'b1, 1'b0, 2'd0, 100);
    push(8, 1, 1'b0, 1'b0, 100, "R2 low width");
    tick(4);
    both(1'b1); tick(5); both(1'b0); tick(8); both(1'b1); tick(5);
    drain("R2");

    // R6: stray stop first, then a second start while running
    do_reset(1'b0, 1'b0, 2'd0, 100);
    push(8, 1, 1'b0, 1'b0, 100, "R6");
    tick(4);
    chan_b = 1'b1; tick(3); chan_b = 1'b0; tick(3);
    chan_a = 1'b1; tick(3); chan_a = 1'b0; tick(2); chan_a = 1'b1; tick(3);
    chan_b = 1'b1; tick(3); chan_a = 1'b0; chan_b = 1'b0; tick(3);
    drain("R6");

    // R5: short hold rejects a 2-cycle glitch on the start channel
    do_reset(1'b0, 1'b0, 2'd1, 150);
    push(12, 1, 1'b0, 1'b0, 150, "R5 short");
    tick(4);
    chan_a = 1'b1; tick(2); chan_a = 1'b0; tick(6);
    chan_b = 1'b1; tick(12); chan_b = 1'b0; tick(12);
    interval(12, 12);
    drain("R5");

    // R5: long hold rejects a 20-cycle glitch
    do_reset(1'b0, 1'b0, 2'd2, 400);
    push(14, 1, 1'b0, 1'b0, 400, "R5 long");
    tick(4);
    chan_a = 1'b1; tick(20); chan_a = 1'b0; tick(6);
    chan_b = 1'b1; tick(55); chan_b = 1'b0; tick(55);
    interval(14, 55);
    drain("R5");

    // R7: interval straddling the gate end lands whole in the next window
    do_reset(1'b0, 1'b0, 2'd0, 60);
    push(5, 1, 1'b0, 1'b0, 60, "R7 first window");
    push(25, 1, 1'b0, 1'b0, 120, "R7 carried interval");
    tick(4);
    interval(5, 3);
    wait_cyc(45);
    chan_a = 1'b1; tick(25); chan_b = 1'b1; tick(3);
    chan_a = 1'b0; chan_b = 1'b0;
    drain("R7");

    // R8: nothing completes, zero report after gate plus tail
    do_reset(1'b0, 1'b0, 2'd0, 50);
    push(0, 0, 1'b1, 1'b0, 50 + TAIL, "R8 timeout zero");
    drain("R8");

    // R8: completion inside the tail is reported at once
    do_reset(1'b0, 1'b0, 2'd0, 50);
    push(25, 1, 1'b0, 1'b0, 0, "R8 tail completion");
    wait_cyc(40);
    chan_a = 1'b1; tick(25); chan_b = 1'b1; tick(3);
    chan_a = 1'b0; chan_b = 1'b0;
    drain("R8");

    // R9: tick sum saturates
    do_reset(1'b0, 1'b0, 2'd0, 400);
    push(255, 3, 1'b0, 1'b1, 400, "R9 sum saturation");
    tick(4);
    interval(100, 3); interval(100, 3); interval(100, 3);
    drain("R9");

    // R9: count saturates, then the flag clears next window
    do_reset(1'b0, 1'b0, 2'd0, 100);
    push(27, 7, 1'b0, 1'b1, 100, "R9 count saturation");
    push(4, 1, 1'b0, 1'b0, 200, "R9 flag cleared");
    tick(2);
    for (int i = 0; i < 9; i++) interval(3, 2);
    wait_cyc(105);
    interval(4, 2);
    drain("R9");

    // R10: result held after the strobe
    tick(20);
    check(int'(sum_o) == 4, "R10", "held sum", int'(sum_o), 4);
    check(int'(count_o) == 1, "R10", "held count", int'(count_o), 1);

    summary();
  end
endmodule